// File: doc/BRIEF.md
# Excess-3 Decimal Adder-Subtractor

This block adds or subtracts two signed decimal numbers of `N_DEC` decades in a single combinational pass. Each decade is stored in Excess-3 form: a 4-bit code equal to the digit value plus three. A separate sign bit sits above the most significant decade. Negative numbers are held in complement form. `MODE` selects the complement at elaboration time: nine's complement or ten's complement.

The datapath works in two stages. First, a plain binary ripple add runs across every decade and into the sign bit. Second, a correction adds three to each decade that carried and removes three from each decade that did not. The correction stays inside its own decade and never creates a new carry, so all decades are corrected side by side.

To subtract, the block inverts every bit of the subtrahend, which is its nine's complement, including its sign. In nine's complement mode, a carry out of the sign bit wraps back into the lowest decade. In ten's complement mode, the initial carry-in is the subtract select and no wrap is used. `REG_OUT` chooses between a combinational output and an output held one clock later.

Top module: `xs3_addsub`

## Requirements
- R1: Decade k occupies bits [4k+3:4k] of each digit bus. Its code is the decimal digit plus 3, so the legal codes are 3 to 12.
- R2: With the sign bit clear, the operand value is the decimal number D formed by its digits. With the sign bit set, the value is -(10^N_DEC-1-D) in nine's mode and D-10^N_DEC in ten's mode. The result uses the same encoding.
- R3: When both operands carry only legal codes, every result decade carries a legal code.
- R4: With `sub_i` low and no overflow, the result value equals a+b.
- R5: With `sub_i` high and no overflow, the result value equals a-b.
- R6: In nine's mode, subtracting an operand from itself gives negative zero: sign set and every decade coded 12.
- R7: In ten's mode, subtracting an operand from itself gives positive zero: sign clear, every decade coded 3 and no overflow.
- R8: `ovf_o` is high exactly when the true result falls outside the representable range. That range is ±(10^N_DEC-1) in nine's mode and -10^N_DEC to 10^N_DEC-1 in ten's mode. Without overflow, adding two operands of equal effective sign keeps that sign.
- R9: With `REG_OUT`=1, the outputs show the result of the inputs present at the previous rising clock edge. While `rst_ni` is low, the outputs are all decades coded 3, sign 0 and `ovf_o` 0.
- R10: With `REG_OUT`=0, the outputs follow the inputs in the same cycle with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_dig_i | input | 4*N_DEC | Operand A decades, Excess-3 |
| a_neg_i | input | 1 | Operand A sign bit |
| b_dig_i | input | 4*N_DEC | Operand B decades, Excess-3 |
| b_neg_i | input | 1 | Operand B sign bit |
| sub_i | input | 1 | 1 selects a-b, 0 selects a+b |
| res_dig_o | output | 4*N_DEC | Result decades, Excess-3 |
| res_neg_o | output | 1 | Result sign bit |
| ovf_o | output | 1 | Result out of range |

## Verification
The assertions on digit legality and the self-subtraction results assume every operand decade carries one of the ten legal codes. Codes 0 to 2 and 13 to 15 are left undefined. The sweep never produces them, because it builds each operand by encoding an integer in the chosen complement form. The sweep covers every pair of two-decade values in each mode with both operations, so every carry pattern and both range edges are reached. Nine's-mode operands skip -100, which that encoding cannot express.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  typedef enum logic {
    CMP_NINES = 1'b0,
    CMP_TENS  = 1'b1
  } cmp_mode_e;

  localparam int unsigned DIG_W    = 4;
  localparam logic [3:0]  XS3_ZERO = 4'h3;
  localparam logic [3:0]  XS3_NINE = 4'hC;
  localparam logic [3:0]  FIX_UP   = 4'h3;
  // nine's complement of 3 in one nibble; with wrap-around carry it subtracts 3
  localparam logic [3:0]  FIX_DN   = 4'hC;

  function automatic logic xs3_legal(input logic [3:0] d);
    return (d >= 4'd3) && (d <= 4'd12);
  endfunction
endpackage

// File: rtl/xs3_decade_add.sv
module xs3_decade_add (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       ci_i,
  output logic [3:0] raw_o,
  output logic       co_o
);
  logic [4:0] sum;
  // both codes carry +3, so bit 4 is exactly the decimal carry
  assign sum   = {1'b0, a_i} + {1'b0, b_i} + {4'd0, ci_i};
  assign raw_o = sum[3:0];
  assign co_o  = sum[4];
endmodule

// File: rtl/xs3_decade_fix.sv
module xs3_decade_fix
  import xs3_pkg::*;
(
  input  logic [3:0] raw_i,
  input  logic       carried_i,
  output logic [3:0] dig_o
);
  logic [4:0] dn_sum;
  logic [3:0] up_val;
  logic [3:0] dn_val;

  assign up_val = raw_i + FIX_UP;
  assign dn_sum = {1'b0, raw_i} + {1'b0, FIX_DN};
  // carry out of the nibble wraps into its own LSB, never to the next decade
  assign dn_val = dn_sum[3:0] + {3'd0, dn_sum[4]};
  assign dig_o  = carried_i ? up_val : dn_val;
endmodule

// File: rtl/xs3_chain.sv
module xs3_chain #(
  parameter int unsigned N_DEC = 4,
  localparam int unsigned W    = 4 * N_DEC
) (
  input  logic [W-1:0]     a_dig_i,
  input  logic [W-1:0]     b_dig_i,
  input  logic             a_neg_i,
  input  logic             b_neg_i,
  input  logic             ci_i,
  output logic [W-1:0]     raw_o,
  output logic [N_DEC-1:0] dco_o,
  output logic             neg_o,
  output logic             sgn_ci_o,
  output logic             sgn_co_o
);
  logic [N_DEC:0] c;
  assign c[0] = ci_i;

  for (genvar k = 0; k < N_DEC; k++) begin : g_dec
    xs3_decade_add u_add (
      .a_i   (a_dig_i[4*k +: 4]),
      .b_i   (b_dig_i[4*k +: 4]),
      .ci_i  (c[k]),
      .raw_o (raw_o[4*k +: 4]),
      .co_o  (c[k+1])
    );
    assign dco_o[k] = c[k+1];
  end

  assign sgn_ci_o = c[N_DEC];
  assign neg_o    = a_neg_i ^ b_neg_i ^ c[N_DEC];
  assign sgn_co_o = (a_neg_i & b_neg_i) | (c[N_DEC] & (a_neg_i ^ b_neg_i));
endmodule

// File: rtl/xs3_addsub.sv
module xs3_addsub
  import xs3_pkg::*;
#(
  parameter int unsigned N_DEC   = 4,
  parameter cmp_mode_e   MODE    = CMP_NINES,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned W      = 4 * N_DEC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_dig_i,
  input  logic         a_neg_i,
  input  logic [W-1:0] b_dig_i,
  input  logic         b_neg_i,
  input  logic         sub_i,
  output logic [W-1:0] res_dig_o,
  output logic         res_neg_o,
  output logic         ovf_o
);
  logic [W-1:0]     b_eff;
  logic             b_neg_eff;
  logic [W-1:0]     raw;
  logic [N_DEC-1:0] dco;
  logic             sum_neg;
  logic             sum_ovf;
  logic [W-1:0]     fix_dig;

  // self-complementing code: bit inversion is the nine's complement
  assign b_eff     = b_dig_i ^ {W{sub_i}};
  assign b_neg_eff = b_neg_i ^ sub_i;

  if (MODE == CMP_NINES) begin : g_nines
    logic [W-1:0]     raw0, raw1;
    logic [N_DEC-1:0] dco0, dco1;
    logic             neg0, neg1, sci0, sci1, sco0, sco1;
    logic             eac;

    xs3_chain #(.N_DEC(N_DEC)) u_p0 (
      .a_dig_i(a_dig_i), .b_dig_i(b_eff), .a_neg_i(a_neg_i), .b_neg_i(b_neg_eff),
      .ci_i(1'b0), .raw_o(raw0), .dco_o(dco0), .neg_o(neg0),
      .sgn_ci_o(sci0), .sgn_co_o(sco0)
    );
    xs3_chain #(.N_DEC(N_DEC)) u_p1 (
      .a_dig_i(a_dig_i), .b_dig_i(b_eff), .a_neg_i(a_neg_i), .b_neg_i(b_neg_eff),
      .ci_i(1'b1), .raw_o(raw1), .dco_o(dco1), .neg_o(neg1),
      .sgn_ci_o(sci1), .sgn_co_o(sco1)
    );

    // end-around carry picks the pass; a second wrap cannot occur
    assign eac     = sco0;
    assign raw     = eac ? raw1 : raw0;
    assign dco     = eac ? dco1 : dco0;
    assign sum_neg = eac ? neg1 : neg0;
    assign sum_ovf = (a_neg_i == b_neg_eff) && (sum_neg != a_neg_i);

    logic unused_nines;
    assign unused_nines = ^{sci0, sci1, sco1};
  end else begin : g_tens
    logic sci, sco;

    xs3_chain #(.N_DEC(N_DEC)) u_p (
      .a_dig_i(a_dig_i), .b_dig_i(b_eff), .a_neg_i(a_neg_i), .b_neg_i(b_neg_eff),
      .ci_i(sub_i), .raw_o(raw), .dco_o(dco), .neg_o(sum_neg),
      .sgn_ci_o(sci), .sgn_co_o(sco)
    );
    assign sum_ovf = sci ^ sco;
  end

  for (genvar k = 0; k < N_DEC; k++) begin : g_fix
    xs3_decade_fix u_fix (
      .raw_i     (raw[4*k +: 4]),
      .carried_i (dco[k]),
      .dig_o     (fix_dig[4*k +: 4])
    );
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_dig_o <= {N_DEC{XS3_ZERO}};
        res_neg_o <= 1'b0;
        ovf_o     <= 1'b0;
      end else begin
        res_dig_o <= fix_dig;
        res_neg_o <= sum_neg;
        ovf_o     <= sum_ovf;
      end
    end
  end else begin : g_comb
    assign res_dig_o = fix_dig;
    assign res_neg_o = sum_neg;
    assign ovf_o     = sum_ovf;

    logic unused_clk;
    assign unused_clk = ^{clk_i, rst_ni};
  end
endmodule

// File: rtl/xs3_addsub_chk.sv
module xs3_addsub_chk
  import xs3_pkg::*;
#(
  parameter int unsigned N_DEC   = 4,
  parameter cmp_mode_e   MODE    = CMP_NINES,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned W      = 4 * N_DEC
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_dig_i,
  input logic         a_neg_i,
  input logic [W-1:0] b_dig_i,
  input logic         b_neg_i,
  input logic         sub_i,
  input logic [W-1:0] res_dig_o,
  input logic         res_neg_o,
  input logic         ovf_o
);
  logic [W-1:0] a_q, b_q;
  logic         an_q, bn_q, sub_q;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q   <= {N_DEC{XS3_ZERO}};
        b_q   <= {N_DEC{XS3_ZERO}};
        an_q  <= 1'b0;
        bn_q  <= 1'b0;
        sub_q <= 1'b0;
      end else begin
        a_q   <= a_dig_i;
        b_q   <= b_dig_i;
        an_q  <= a_neg_i;
        bn_q  <= b_neg_i;
        sub_q <= sub_i;
      end
    end
  end else begin : g_now
    assign a_q   = a_dig_i;
    assign b_q   = b_dig_i;
    assign an_q  = a_neg_i;
    assign bn_q  = b_neg_i;
    assign sub_q = sub_i;
  end

  logic in_legal;
  logic same_sign;
  logic self_sub;

  always_comb begin
    in_legal = 1'b1;
    for (int k = 0; k < N_DEC; k++) begin
      in_legal &= xs3_legal(a_q[4*k +: 4]) & xs3_legal(b_q[4*k +: 4]);
    end
  end

  assign same_sign = (an_q == (bn_q ^ sub_q));
  assign self_sub  = sub_q && (a_q == b_q) && (an_q == bn_q) && in_legal;

  for (genvar k = 0; k < N_DEC; k++) begin : g_dig
    a_r3_digits_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_legal |-> xs3_legal(res_dig_o[4*k +: 4]));
  end

  a_r8_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_legal && same_sign && !ovf_o) |-> (res_neg_o == an_q));

  if (MODE == CMP_NINES) begin : g_a_nines
    a_r6_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      self_sub |-> (res_neg_o && (res_dig_o == {N_DEC{XS3_NINE}}) && !ovf_o));
  end else begin : g_a_tens
    a_r7_pos_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      self_sub |-> (!res_neg_o && (res_dig_o == {N_DEC{XS3_ZERO}}) && !ovf_o));
    a_r8_ovf_same_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> same_sign);
  end
endmodule

bind xs3_addsub xs3_addsub_chk #(
  .N_DEC(N_DEC), .MODE(MODE), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .a_dig_i(a_dig_i), .a_neg_i(a_neg_i),
  .b_dig_i(b_dig_i), .b_neg_i(b_neg_i),
  .sub_i(sub_i),
  .res_dig_o(res_dig_o), .res_neg_o(res_neg_o), .ovf_o(ovf_o)
);

// File: tb/tb_xs3_addsub.sv
module tb_xs3_addsub;
  import xs3_pkg::*;

  localparam int N_DEC  = 2;
  localparam int W      = 4 * N_DEC;
  localparam int LIM    = 100;
  localparam int CLK_PD = 10;
  localparam int WD_CYC = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PD/2) clk = ~clk;

  logic [W-1:0] n_a, n_b, n_r, t_a, t_b, t_r;
  logic n_an, n_bn, n_rn, n_ov, t_an, t_bn, t_rn, t_ov, sub;

  xs3_addsub #(.N_DEC(N_DEC), .MODE(CMP_NINES), .REG_OUT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_dig_i(n_a), .a_neg_i(n_an),
    .b_dig_i(n_b), .b_neg_i(n_bn), .sub_i(sub),
    .res_dig_o(n_r), .res_neg_o(n_rn), .ovf_o(n_ov));

  xs3_addsub #(.N_DEC(N_DEC), .MODE(CMP_TENS), .REG_OUT(1'b1)) dut_tc (
    .clk_i(clk), .rst_ni(rst_n), .a_dig_i(t_a), .a_neg_i(t_an),
    .b_dig_i(t_b), .b_neg_i(t_bn), .sub_i(sub),
    .res_dig_o(t_r), .res_neg_o(t_rn), .ovf_o(t_ov));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R1/R2 encoding: digit+3 per nibble, sign bit selects complement form
  function automatic logic [W:0] enc(input int v, input bit tens);
    logic [W-1:0] d;
    int m;
    m = (v < 0) ? (tens ? LIM + v : LIM - 1 + v) : v;
    for (int k = 0; k < N_DEC; k++) begin
      d[4*k +: 4] = 4'((m % 10) + 3);
      m = m / 10;
    end
    return {(v < 0), d};
  endfunction

  function automatic int dec(input logic [W-1:0] d, input logic neg, input bit tens);
    int m = 0;
    int p = 1;
    for (int k = 0; k < N_DEC; k++) begin
      m += (int'(d[4*k +: 4]) - 3) * p;
      p *= 10;
    end
    if (!neg) return m;
    return tens ? m - LIM : -(LIM - 1 - m);
  endfunction

  function automatic bit legal_all(input logic [W-1:0] d);
    for (int k = 0; k < N_DEC; k++)
      if (!xs3_legal(d[4*k +: 4])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_tc(input int r, input bit s, input bit self);
    bit eo;
    eo = (r > LIM - 1) || (r < -LIM);
    chk(t_ov == eo, "R8 tens ovf", int'(t_ov), int'(eo));
    if (!eo) begin
      chk(legal_all(t_r), "R3 tens legal", int'(t_r), 0);
      chk(dec(t_r, t_rn, 1'b1) == r, s ? "R5 tens sub" : "R4 tens add",
          dec(t_r, t_rn, 1'b1), r);
    end
    if (self)
      chk(!t_rn && t_r == {N_DEC{XS3_ZERO}}, "R7 tens self-sub", int'({t_rn, t_r}), 8'h33);
  endtask

  logic [W:0] ea, eb;
  int  prev_r;
  bit  prev_s, prev_self, prev_valid, prev_ovf;

  initial begin
    n_a = '0; n_b = '0; n_an = 0; n_bn = 0; t_a = '0; t_b = '0; t_an = 0; t_bn = 0; sub = 0;
    prev_valid = 0; prev_r = 0; prev_s = 0; prev_self = 0; prev_ovf = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(t_r == {N_DEC{XS3_ZERO}} && !t_rn && !t_ov, "R9 reset", int'({t_ov, t_rn, t_r}), 8'h33);
    rst_n = 1'b1;

    for (int va = -LIM; va < LIM; va++) begin
      for (int vb = -LIM; vb < LIM; vb++) begin
        for (int s = 0; s < 2; s++) begin
          int  r;
          bit  nine_on, eo;
          @(negedge clk);
          if (prev_valid) check_tc(prev_r, prev_s, prev_self);
          r = (s == 1) ? va - vb : va + vb;
          nine_on = (va > -LIM) && (vb > -LIM);
          ea = enc(va, 1'b1); eb = enc(vb, 1'b1);
          t_a = ea[W-1:0]; t_an = ea[W]; t_b = eb[W-1:0]; t_bn = eb[W];
          ea = enc(nine_on ? va : 0, 1'b0); eb = enc(nine_on ? vb : 0, 1'b0);
          n_a = ea[W-1:0]; n_an = ea[W]; n_b = eb[W-1:0]; n_bn = eb[W];
          sub = (s == 1);
          #1;
          // R10: combinational result checked in the same cycle as the drive
          if (nine_on) begin
            eo = (r > LIM - 1) || (r < -(LIM - 1));
            chk(n_ov == eo, "R8 nines ovf", int'(n_ov), int'(eo));
            if (!eo) begin
              chk(legal_all(n_r), "R3 nines legal", int'(n_r), 0);
              chk(dec(n_r, n_rn, 1'b0) == r, (s == 1) ? "R5 nines sub" : "R4 nines add",
                  dec(n_r, n_rn, 1'b0), r);
            end
            if (s == 1 && va == vb)
              chk(n_rn && n_r == {N_DEC{XS3_NINE}}, "R6 nines self-sub",
                  int'({n_rn, n_r}), 9'h1CC);
          end
          // R9 latency: registered copy still shows the previous result
          if (prev_valid && !prev_ovf)
            chk(dec(t_r, t_rn, 1'b1) == prev_r, "R9 latency", dec(t_r, t_rn, 1'b1), prev_r);
          prev_valid = 1; prev_r = r; prev_s = (s == 1);
          prev_self = (s == 1) && (va == vb);
          prev_ovf = (r > LIM - 1) || (r < -LIM);
        end
      end
    end
    @(negedge clk);
    check_tc(prev_r, prev_s, prev_self);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", WD_CYC, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule